// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a cycle-level digital model of a clock distribution matrix with four output sections. A fast tick clock stands for the time unit: one tick is one unit of skew. From it the block builds a nominal clock. The nominal period is N ticks, and N comes from a three-level range select. Each section has one pair of outputs. Both outputs of a pair carry the same signal. Two three-level selects per section pick one of nine functions: a signed delay counted in ticks, a divide-by-2 clock, a divide-by-4 clock, or an inverted clock.

Each three-level select arrives as a 2-bit code. A three-level test select can bypass the internal timebase. In bypass, the level of an external reference drives the outputs directly. Every section still applies its own function to that reference.

Top module: `skew_clk_matrix`

## Requirements
- R1: A three-level code is read as LOW for 00, MID for 01 and HIGH for 10. The code 11 is read as MID. This holds for the range, test and function selects.
- R2: The range select sets the nominal period N: LOW gives 44 ticks, MID gives 26 ticks and HIGH gives 16 ticks. A phase count runs from 0 to N-1 and advances once per tick. The nominal clock is high while the phase is below N/2. A synchronous reset sets the phase to 0.
- R3: Sections 1 and 2 form a value v = 3*F1 + F0, where LOW=0, MID=1 and HIGH=2. The output is a skewed copy of the nominal clock, delayed by v-4 ticks. It is high when ((phase - (v-4)) mod N) < N/2, so a positive delay makes the output late.
- R4: Sections 3 and 4, for v from 1 to 7, delay the nominal clock by 2*(v-4) ticks, using the same rule as R3.
- R5: In section 3, v=0 selects divide-by-2 and v=8 selects divide-by-4. In section 4, v=0 selects divide-by-2 and v=8 selects the complement of the nominal clock.
- R6: Reset clears the divide-by-2 and divide-by-4 states to low. The divide-by-2 state toggles on the tick where the nominal clock falls. The divide-by-4 state toggles on each falling edge of the divide-by-2 state, so every fall of divide-by-4 lands on a fall of divide-by-2.
- R7: The two outputs of a pair (q0[s] and q1[s]) are always equal.
- R8: When the test select reads MID or HIGH, every skew code drives its output with the reference level itself, and the section 4 invert code drives the complement of the reference.
- R9: In bypass, the divider states toggle on reference falls instead of nominal falls. A reference fall is a tick where the reference is sampled low after being sampled high on the previous tick. The reference sample register is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one cycle is one time unit |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 2 | Three-level range select that sets the period N |
| test_sel | input | 2 | Three-level test select; MID or HIGH bypasses the timebase |
| ref_in | input | 1 | External reference level, used in bypass |
| fsel_hi | input | 8 | F1 codes; bits [2s+1:2s] belong to section s+1 |
| fsel_lo | input | 8 | F0 codes; bits [2s+1:2s] belong to section s+1 |
| q0 | output | 4 | First output of each pair; bit s belongs to section s+1 |
| q1 | output | 4 | Second output of each pair; bit s belongs to section s+1 |

## Verification
The bench targets several corner cases, each with a typical wrong result:
- Extreme skews make the phase wrap in both directions. A faulty modulo shows up as a shifted or truncated high window near phase 0 and near N-1.
- The wider step of sections 3 and 4 is checked against the unit step of sections 1 and 2. Swapping the two scales moves the edges by the wrong amount.
- The extreme codes are checked per section. A design that confuses divide-by-4 with the inverter, or places the divide in the wrong section, gives a clock of the wrong frequency on that pair.
- The divider states are checked against the nominal fall count and, in bypass, against the reference fall count. A design that toggles on rising edges, or that lets divide-by-4 fall off a divide-by-2 fall, gives outputs that are out of phase by half a period.
- Code 11 must be read as MID. A design that reads it as HIGH picks the short period and the wrong functions.

// File: rtl/skew_clk_matrix.sv
module skew_clk_matrix #(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] range_sel,
  input  logic [1:0] test_sel,
  input  logic       ref_in,
  input  logic [7:0] fsel_hi,
  input  logic [7:0] fsel_lo,
  output logic [3:0] q0,
  output logic [3:0] q1
);
  localparam int NMAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                        : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
  localparam int PW = $clog2(2 * NMAX + 8);

  function automatic logic [1:0] lvl(input logic [1:0] c);
    return (c == 2'b11) ? 2'b01 : c;
  endfunction

  logic [PW-1:0] nlen, half, twon, phase;
  logic          bypass, nom, ref_q, div2, div4, fall_evt;

  always_comb begin
    case (lvl(range_sel))
      2'b00:   nlen = PW'(N_LOW);
      2'b01:   nlen = PW'(N_MID);
      default: nlen = PW'(N_HIGH);
    endcase
  end

  assign half     = nlen >> 1;
  assign twon     = nlen << 1;
  assign bypass   = lvl(test_sel) != 2'b00;
  assign nom      = phase < half;
  assign fall_evt = bypass ? (ref_q & ~ref_in) : (phase == half - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      ref_q <= 1'b0;
      div2  <= 1'b0;
      div4  <= 1'b0;
    end else begin
      phase <= (phase >= nlen - PW'(1)) ? '0 : phase + PW'(1);
      ref_q <= ref_in;
      if (fall_evt) begin
        div2 <= ~div2;
        if (div2) div4 <= ~div4;
      end
    end
  end

  for (genvar s = 0; s < 4; s++) begin : g_sec
    logic [3:0]    v, kofs;
    logic [PW-1:0] t1, t2;
    logic          skw, o;

    assign v = {2'b00, lvl(fsel_hi[2*s+1:2*s])} + {1'b0, lvl(fsel_hi[2*s+1:2*s]), 1'b0}
             + {2'b00, lvl(fsel_lo[2*s+1:2*s])};

    if (s < 2) begin : g_unit
      assign kofs = v + 4'd2;
    end else begin : g_double
      assign kofs = (v == 4'd0) ? 4'd6 : ({v[2:0], 1'b0} - 4'd2);
    end

    assign t1  = phase + nlen + PW'(6) - PW'(kofs);
    assign t2  = (t1 >= twon) ? t1 - twon : (t1 >= nlen) ? t1 - nlen : t1;
    assign skw = bypass ? ref_in : (t2 < half);

    if (s == 2) begin : g_div
      assign o = (v == 4'd0) ? div2 : (v == 4'd8) ? div4 : skw;
    end else if (s == 3) begin : g_inv
      assign o = (v == 4'd0) ? div2 : (v == 4'd8) ? (bypass ? ~ref_in : ~nom) : skw;
    end else begin : g_plain
      assign o = skw;
    end

    assign q0[s] = o;
    assign q1[s] = o;
  end
endmodule

// File: rtl/skew_clk_matrix_chk.sv
module skew_clk_matrix_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          bypass,
  input logic          nom,
  input logic          div2,
  input logic          div4,
  input logic [PW-1:0] phase,
  input logic          ref_in,
  input logic [7:0]    fsel_hi,
  input logic [7:0]    fsel_lo,
  input logic [3:0]    q0
);
  // R6
  div4_fall_align_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(div4) |-> $fell(div2));

  // R6
  div2_on_nom_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && $past(!bypass) && (div2 != $past(div2))) |-> $fell(nom));

  // R2
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase == '0 && !div2 && !div4));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass && fsel_hi[1:0] == 2'b01 && fsel_lo[1:0] == 2'b01) |-> (q0[0] == ref_in));

  // R5
  invert_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && fsel_hi[7:6] == 2'b10 && fsel_lo[7:6] == 2'b10) |-> (q0[3] != nom));
endmodule

bind skew_clk_matrix skew_clk_matrix_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst(rst), .bypass(bypass), .nom(nom), .div2(div2), .div4(div4),
  .phase(phase), .ref_in(ref_in), .fsel_hi(fsel_hi), .fsel_lo(fsel_lo), .q0(q0)
);

// File: tb/skew_clk_matrix_tb_top.sv
module skew_clk_matrix_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] range_sel = 2'b01;
  logic [1:0] test_sel = 2'b00;
  logic       ref_in = 1'b0;
  logic [7:0] fsel_hi = 8'h55;
  logic [7:0] fsel_lo = 8'h55;
  logic [3:0] q0, q1;

  int checks = 0;
  int errors = 0;
  int tk = 0;
  int rf = 0;
  logic rp = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  skew_clk_matrix dut_i (
    .clk(clk), .rst(rst), .range_sel(range_sel), .test_sel(test_sel), .ref_in(ref_in),
    .fsel_hi(fsel_hi), .fsel_lo(fsel_lo), .q0(q0), .q1(q1)
  );

  always @(posedge clk) begin
    if (rst) begin
      tk <= 0; rf <= 0; rp <= 1'b0;
    end else begin
      tk <= tk + 1;
      rp <= ref_in;
      if (rp && !ref_in) rf <= rf + 1;
    end
  end

  function automatic int lv(logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic int period_of(logic [1:0] r);
    case (lv(r))
      0: return 44;
      1: return 26;
      default: return 16;
    endcase
  endfunction

  function automatic logic expect_bit(int s, logic [1:0] h, logic [1:0] l, int t, int n,
                                      bit byp, logic r, int rfc);
    int v, ph, falls, k;
    logic d2, d4, nomv;
    v = 3 * lv(h) + lv(l);
    ph = t % n;
    nomv = ph < n / 2;
    falls = byp ? rfc : ((t >= n / 2) ? (t - n / 2) / n + 1 : 0);
    d2 = (falls % 2) == 1;
    d4 = (falls % 4) >= 2;
    if (s >= 2 && v == 0) return d2;
    if (s == 2 && v == 8) return d4;
    if (s == 3 && v == 8) return byp ? !r : !nomv;
    if (byp) return r;
    k = (s < 2) ? v - 4 : 2 * (v - 4);
    return (((ph - k) % n + n) % n) < n / 2;
  endfunction

  task automatic check_now(string tag);
    logic [3:0] ev;
    int n;
    bit byp;
    n = period_of(range_sel);
    byp = lv(test_sel) != 0;
    for (int s = 0; s < 4; s++)
      ev[s] = expect_bit(s, fsel_hi[2*s+1 -: 2], fsel_lo[2*s+1 -: 2], tk, n, byp, ref_in, rf);
    checks++;
    if (q0 !== ev) begin
      errors++;
      $display("FAIL %s tick %0d: q0 actual %b expected %b", tag, tk, q0, ev);
    end
    checks++;
    if (q1 !== q0) begin
      errors++;
      $display("FAIL R7 tick %0d: q1 actual %b expected %b", tk, q1, q0);
    end
  endtask

  task automatic run_cfg(string tag, logic [1:0] rng, logic [1:0] tst,
                         logic [7:0] hi, logic [7:0] lo, int cycles, int refp);
    @(negedge clk);
    rst = 1'b1; range_sel = rng; test_sel = tst; fsel_hi = hi; fsel_lo = lo; ref_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now(tag);
      ref_in = (refp > 0) ? (((i * 7 + i / 3) % refp) < refp / 2) : 1'b0;
    end
  endtask

  // R2: reset state and the three periods, all sections at zero skew
  task automatic t_ranges();
    run_cfg("R2 mid", 2'b01, 2'b00, 8'h55, 8'h55, 60, 0);
    run_cfg("R2 low", 2'b00, 2'b00, 8'h55, 8'h55, 95, 0);
    run_cfg("R2 high", 2'b10, 2'b00, 8'h55, 8'h55, 40, 0);
  endtask

  // R3: all nine codes on sections 1 and 2
  task automatic t_unit_skew();
    for (int v = 0; v < 9; v++) begin
      logic [1:0] h, l, h2, l2;
      h = 2'(v / 3); l = 2'(v % 3);
      h2 = 2'((8 - v) / 3); l2 = 2'((8 - v) % 3);
      run_cfg("R3", (v % 2) ? 2'b10 : 2'b01, 2'b00, {4'h5, h2, h}, {4'h5, l2, l}, 40, 0);
    end
  endtask

  // R4: the seven skew codes on sections 3 and 4
  task automatic t_double_skew();
    for (int v = 1; v < 8; v++) begin
      logic [1:0] h, l, h2, l2;
      h = 2'(v / 3); l = 2'(v % 3);
      h2 = 2'((8 - v) / 3); l2 = 2'((8 - v) % 3);
      run_cfg("R4", (v % 2) ? 2'b00 : 2'b10, 2'b00, {h2, h, 4'h5}, {l2, l, 4'h5}, 50, 0);
    end
  endtask

  // R5 R6: divide and invert codes with divider phase from reset
  task automatic t_functions();
    run_cfg("R5 R6 div2/inv", 2'b10, 2'b00, 8'b10_00_01_01, 8'b10_00_01_01, 140, 0);
    run_cfg("R5 R6 div4/div2", 2'b01, 2'b00, 8'b00_10_00_10, 8'b00_10_00_10, 220, 0);
  endtask

  // R1: code 11 read as MID on range and selects
  task automatic t_code11();
    run_cfg("R1", 2'b11, 2'b00, 8'b11_11_00_11, 8'b11_00_10_11, 60, 0);
    run_cfg("R1 test", 2'b10, 2'b11, 8'hFF, 8'hFF, 30, 6);
  endtask

  // R8 R9: bypass follows reference; dividers count reference falls
  task automatic t_bypass();
    run_cfg("R8 R9 mid", 2'b00, 2'b01, 8'b10_00_00_10, 8'b10_00_01_00, 80, 6);
    run_cfg("R8 R9 high", 2'b01, 2'b10, 8'b00_10_01_01, 8'b00_10_01_10, 120, 10);
  endtask

  initial begin
    t_ranges();
    t_unit_skew();
    t_double_skew();
    t_functions();
    t_code11();
    t_bypass();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule